// File: doc/BRIEF.md
# Reset Sequencer with Power-Up Delay

This block produces the internal system reset of a microcontroller. Four causes can start a reset: the supply reaching its good level, a low level on the external active-low reset pin, a failure flag from the watchdog, and a failure flag from the clock monitor. The clock monitor raises its flag when it detects a clock below 10 kHz. The supply-good input is a digital level. While it is low, the whole block is cleared asynchronously. Its rise starts a long stabilisation hold before the reset is released. Every other cause gives a shorter hold. Reset saves no register state, so the block only decides when reset is asserted and why.

The reset pin is bidirectional on the board. While reset is active, the block drives the pin low itself, and the pin filter is blanked during that time so that the block's own drive can never start a new reset. The pin is synchronised and then filtered, so that only a low level held for several consecutive samples counts as a reset request. At each reset entry the block latches a priority-encoded cause code, a vector-class selector and a mask of every request present in that cycle. All three hold until the next entry.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_ok_i` is low, `sys_rst_o` and `rst_pin_drive_o` are 1, `cause_o` is 0 (power-up), `vec_sel_o` is 0 and `cause_hit_o` is 4'b0001. This holds asynchronously, without any clock edge.
- R2: After `pwr_ok_i` rises, `sys_rst_o` stays 1 through rising edges 1 to POR_CYCLES-1 (default 4096) and falls at rising edge POR_CYCLES.
- R3: A low on the pin is accepted only when the synchronised pin (SYNC_STAGES=2 flops) has been low for MIN_LOW=6 consecutive edges. A pin first sampled low at edge 1 and held for at least 6 samples asserts reset at edge 8. A shorter low has no effect.
- R4: A reset started by the pin, the watchdog or the clock monitor keeps `sys_rst_o` high for exactly SHORT_HOLD (default 16) cycles after the entry edge.
- R5: A `wdog_fail_i` high at a rising edge outside reset enters reset at that edge, with cause code 2 and `vec_sel_o` = 1.
- R6: A `clkmon_fail_i` high at a rising edge outside reset enters reset at that edge, with cause code 3 and `vec_sel_o` = 2.
- R7: When several requests arrive at the same edge, the cause code is the lowest-numbered one: pin (1), then watchdog (2), then clock monitor (3). A pin entry gives `vec_sel_o` = 0.
- R8: `cause_hit_o` records every request present at the entry edge. Bit 0 is power-up, bit 1 the pin, bit 2 the watchdog and bit 3 the clock monitor.
- R9: Requests that arrive while `sys_rst_o` is high are ignored. They neither lengthen the hold nor change `cause_o`, `vec_sel_o` or `cause_hit_o`.
- R10: `rst_pin_drive_o` equals `sys_rst_o`. The block's own drive of the pin never causes a further reset after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| pwr_ok_i | input | 1 | Supply-good level; low clears the block, rise starts the power-up hold |
| rst_pin_i | input | 1 | Level seen on the external active-low reset pin |
| wdog_fail_i | input | 1 | Watchdog failure flag |
| clkmon_fail_i | input | 1 | Clock-monitor failure flag (clock below 10 kHz) |
| sys_rst_o | output | 1 | Internal system reset, active high |
| rst_pin_drive_o | output | 1 | 1 = pull the external reset pin low |
| cause_o | output | 2 | Latched cause code: 0 power-up, 1 pin, 2 watchdog, 3 clock monitor |
| vec_sel_o | output | 2 | Vector class: 0 power-up or pin, 1 watchdog, 2 clock monitor |
| cause_hit_o | output | 4 | Mask of all requests seen at the last entry edge |

## Verification
The pin filter's completion and the failure flags can land on the same edge. So can the watchdog and clock-monitor flags. The bench provokes the first case by raising the watchdog flag for one cycle, timed so that it is sampled at the eighth edge of a pin low, the edge where the filter accepts. It provokes the second by raising both flags together. Each case is judged on the cycle of entry, the length of the hold, the priority-encoded code and the hit mask, which must contain both bits. A flag raised in the middle of a hold checks that the hold does not stretch and the latched cause does not change.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    CAUSE_PWR    = 2'd0,
    CAUSE_PIN    = 2'd1,
    CAUSE_WDOG   = 2'd2,
    CAUSE_CLKMON = 2'd3
  } cause_e;

  localparam int unsigned NUM_CAUSES = 4;

  // lowest-numbered request wins
  function automatic cause_e pick_cause(input logic [NUM_CAUSES-1:0] req);
    cause_e c;
    c = CAUSE_PWR;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (req[i]) c = cause_e'(2'(i));
    end
    return c;
  endfunction

  // vector class: power-up and pin share one
  function automatic logic [1:0] vec_of(input cause_e c);
    logic [1:0] v;
    case (c)
      CAUSE_WDOG:   v = 2'd1;
      CAUSE_CLKMON: v = 2'd2;
      default:      v = 2'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 6
) (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic pin_i,
  input  logic blank_i,
  output logic accept_o,
  output logic pin_low_o
);

  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   pin_low;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) sync_q <= '1;
        else          sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) sync_q <= '1;
        else          sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_low   = !sync_q[SYNC_STAGES-1];
  assign pin_low_o = pin_low;

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i)                   run_q <= '0;
    else if (blank_i || !pin_low)   run_q <= '0;
    else if (run_q != LAST)         run_q <= run_q + 1'b1;
  end

  assign accept_o = !blank_i && pin_low && (run_q == LAST);

  // a request needs a low run, so the last two samples must both be low
  p_filter_run_r3: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    accept_o |-> (pin_low && $past(pin_low)));

endmodule

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer #(
  parameter int unsigned POR_CYCLES = 4096,
  parameter int unsigned SHORT_HOLD = 16
) (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic enter_i,
  output logic active_o,
  output logic release_o
);

  localparam int unsigned MAXH = (POR_CYCLES > SHORT_HOLD) ? POR_CYCLES : SHORT_HOLD;
  localparam int unsigned HW   = $clog2(MAXH + 1);
  localparam logic [HW-1:0] POR_LOAD   = HW'(POR_CYCLES - 1);
  localparam logic [HW-1:0] SHORT_LOAD = HW'(SHORT_HOLD - 1);

  logic          active_q;
  logic [HW-1:0] left_q;

  assign release_o = active_q && (left_q == '0);
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) begin
      active_q <= 1'b1;
      left_q   <= POR_LOAD;
    end else if (active_q) begin
      if (release_o) active_q <= 1'b0;
      else           left_q   <= left_q - 1'b1;
    end else if (enter_i) begin
      active_q <= 1'b1;
      left_q   <= SHORT_LOAD;
    end
  end

  p_hold_stays_r2: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (active_q && left_q != '0) |=> active_q);

  p_hold_ends_r4: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (active_q && left_q == '0) |=> !active_q);

  p_enter_idle_r9: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    enter_i |-> !active_q);

endmodule

// File: rtl/rstseq_cause_latch.sv
module rstseq_cause_latch
  import rstseq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  clr_n_i,
  input  logic                  enter_i,
  input  logic [NUM_CAUSES-1:0] req_i,
  output cause_e                cause_o,
  output logic [1:0]            vec_o,
  output logic [NUM_CAUSES-1:0] hit_o
);

  cause_e                cause_q;
  logic [NUM_CAUSES-1:0] hit_q;

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) begin
      cause_q <= CAUSE_PWR;
      hit_q   <= NUM_CAUSES'(1);
    end else if (enter_i) begin
      cause_q <= pick_cause(req_i);
      hit_q   <= req_i;
    end
  end

  assign cause_o = cause_q;
  assign hit_o   = hit_q;
  assign vec_o   = vec_of(cause_q);

  p_cause_stable_r9: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    !enter_i |=> ($stable(cause_q) && $stable(hit_q)));

  p_hit_on_entry_r8: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    enter_i |=> (hit_q != '0));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 4096,
  parameter int unsigned SHORT_HOLD  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 6
) (
  input  logic       clk_i,
  input  logic       pwr_ok_i,
  input  logic       rst_pin_i,
  input  logic       wdog_fail_i,
  input  logic       clkmon_fail_i,
  output logic       sys_rst_o,
  output logic       rst_pin_drive_o,
  output logic [1:0] cause_o,
  output logic [1:0] vec_sel_o,
  output logic [3:0] cause_hit_o
);

  logic                  active;
  logic                  release_evt;
  logic                  pin_accept;
  logic                  pin_low;
  logic                  enter_evt;
  logic [NUM_CAUSES-1:0] req_vec;
  cause_e                cause;

  rstseq_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_LOW     (MIN_LOW)
  ) u_filter (
    .clk_i     (clk_i),
    .clr_n_i   (pwr_ok_i),
    .pin_i     (rst_pin_i),
    .blank_i   (active),
    .accept_o  (pin_accept),
    .pin_low_o (pin_low)
  );

  // bit order is the priority order of the cause code
  assign req_vec   = {clkmon_fail_i, wdog_fail_i, pin_accept, 1'b0};
  assign enter_evt = !active && (req_vec != '0);

  rstseq_hold_timer #(
    .POR_CYCLES (POR_CYCLES),
    .SHORT_HOLD (SHORT_HOLD)
  ) u_hold (
    .clk_i     (clk_i),
    .clr_n_i   (pwr_ok_i),
    .enter_i   (enter_evt),
    .active_o  (active),
    .release_o (release_evt)
  );

  rstseq_cause_latch u_cause (
    .clk_i   (clk_i),
    .clr_n_i (pwr_ok_i),
    .enter_i (enter_evt),
    .req_i   (req_vec),
    .cause_o (cause),
    .vec_o   (vec_sel_o),
    .hit_o   (cause_hit_o)
  );

  assign sys_rst_o       = active;
  assign rst_pin_drive_o = active;
  assign cause_o         = cause;

  // after release, the echo of the block's own drive must not re-enter
  p_no_echo_r10: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    release_evt |=> !pin_accept);

endmodule

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int POR_N  = 4096;
  localparam int HOLD_N = 16;
  localparam int PIN_LAT = 2 + 6;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0;
  logic ext_low = 1'b0;
  logic wdog = 1'b0;
  logic cmon = 1'b0;
  logic pin_lvl;
  logic sys_rst, drive;
  logic [1:0] cause, vsel;
  logic [3:0] hit;

  int checks = 0;
  int errors = 0;
  logic [3:0] last_hit = 4'b0001;

  always #2.5 clk = ~clk;

  assign pin_lvl = !(ext_low || drive);

  rstseq_top u_rstseq_top (
    .clk_i           (clk),
    .pwr_ok_i        (pwr_ok),
    .rst_pin_i       (pin_lvl),
    .wdog_fail_i     (wdog),
    .clkmon_fail_i   (cmon),
    .sys_rst_o       (sys_rst),
    .rst_pin_drive_o (drive),
    .cause_o         (cause),
    .vec_sel_o       (vsel),
    .cause_hit_o     (hit)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int code_of(input logic [3:0] h);
    if (h[0]) return 0;
    if (h[1]) return 1;
    if (h[2]) return 2;
    if (h[3]) return 3;
    return 0;
  endfunction

  function automatic int vec_for(input int c);
    return (c < 2) ? 0 : c - 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // k=0 is the current mid-cycle; stimulus set at k is sampled at edge k+1
  task automatic run_case(input int ext_len, input int wd_at, input int cm_at,
                          input int exp_from, input int exp_to,
                          input logic [3:0] exp_hit, input string rq);
    int bad_k = -1;
    int bad_act = 0;
    int bad_exp = 0;
    for (int k = 0; k <= 30; k++) begin
      if (k > 0) begin
        tick();
        if (bad_k < 0) begin
          if ((sys_rst !== (k >= exp_from && k < exp_to)) || (drive !== sys_rst)) begin
            bad_k = k;
            bad_act = {30'd0, drive, sys_rst};
            bad_exp = (k >= exp_from && k < exp_to) ? 3 : 0;
          end
        end
      end
      ext_low = (k < ext_len);
      wdog    = (k == wd_at);
      cmon    = (k == cm_at);
    end
    ext_low = 1'b0; wdog = 1'b0; cmon = 1'b0;
    repeat (4) tick();
    if (bad_k >= 0) $display("  (%s mismatch at edge %0d)", rq, bad_k);
    chk(bad_k < 0, {rq, " reset window"}, bad_act, bad_exp);
    chk(hit === exp_hit, {rq, " R8 hit mask"}, int'(hit), int'(exp_hit));
    chk(cause === 2'(code_of(exp_hit)), {rq, " R7 cause"}, int'(cause), code_of(exp_hit));
    chk(vsel === 2'(vec_for(code_of(exp_hit))), {rq, " vector"}, int'(vsel),
        vec_for(code_of(exp_hit)));
    last_hit = exp_hit;
  endtask

  task automatic power_up(input bool_wd, input string rq);
    int bad_k = -1;
    pwr_ok = 1'b1;
    for (int k = 1; k <= POR_N + 4; k++) begin
      tick();
      if (bad_k < 0 && (sys_rst !== (k < POR_N))) bad_k = k;
      wdog = bool_wd && (k == 100);
    end
    wdog = 1'b0;
    if (bad_k >= 0) $display("  (%s mismatch at edge %0d)", rq, bad_k);
    chk(bad_k < 0, {rq, " R2 power-up hold length"}, bad_k, -1);
    chk(cause === 2'd0 && hit === 4'b0001, {rq, " R9 cause kept through power-up hold"},
        int'(hit), 1);
    last_hit = 4'b0001;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL timeout (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state without power
    chk(sys_rst === 1'b1 && drive === 1'b1, "R1 reset held while unpowered", int'(sys_rst), 1);
    chk(cause === 2'd0 && vsel === 2'd0 && hit === 4'b0001, "R1 power-up cause", int'(hit), 1);

    // R2 hold, with a watchdog pulse inside it (R9)
    power_up(1'b1, "por1");

    // R3 sweep of pin low lengths; R4 hold length; R10 no echo re-entry
    for (int len = 1; len <= 10; len++) begin
      if (len >= 6)
        run_case(len, -1, -1, PIN_LAT, PIN_LAT + HOLD_N, 4'b0010, $sformatf("R3 pin len=%0d", len));
      else
        run_case(len, -1, -1, 0, 0, last_hit, $sformatf("R3 short pin len=%0d", len));
    end

    // R5 watchdog, R6 clock monitor at various start offsets
    for (int d = 0; d < 3; d++) begin
      run_case(0, d, -1, d + 1, d + 1 + HOLD_N, 4'b0100, $sformatf("R5 wdog at=%0d", d));
      run_case(0, -1, d, d + 1, d + 1 + HOLD_N, 4'b1000, $sformatf("R6 clkmon at=%0d", d));
    end

    // R7/R8 coincidences
    run_case(0, 0, 0, 1, 1 + HOLD_N, 4'b1100, "R7 wdog+clkmon same edge");
    run_case(6, PIN_LAT - 1, -1, PIN_LAT, PIN_LAT + HOLD_N, 4'b0110, "R7 pin+wdog same edge");
    run_case(7, -1, PIN_LAT - 1, PIN_LAT, PIN_LAT + HOLD_N, 4'b1010, "R7 pin+clkmon same edge");
    run_case(6, PIN_LAT - 1, PIN_LAT - 1, PIN_LAT, PIN_LAT + HOLD_N, 4'b1110, "R8 three at once");

    // R9 requests during a hold are ignored
    run_case(0, 0, 5, 1, 1 + HOLD_N, 4'b0100, "R9 clkmon during wdog hold");
    run_case(12, 0, -1, 1, 1 + HOLD_N, 4'b0100, "R9 pin low during wdog hold");

    // R10 idle window after several resets: no spontaneous re-entry
    run_case(0, -1, -1, 0, 0, last_hit, "R10 quiet after release");

    // R1 asynchronous clear mid-operation, then a second power-up
    pwr_ok = 1'b0;
    #0.5;
    chk(sys_rst === 1'b1 && drive === 1'b1, "R1 async assert on power loss", int'(sys_rst), 1);
    chk(cause === 2'd0 && hit === 4'b0001, "R1 cause back to power-up", int'(hit), 1);
    repeat (2) tick();
    power_up(1'b0, "por2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule